// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Booth Signed Mode

This block multiplies two 32-bit operands over a sequence of clock cycles and returns a 64-bit product. A single 64-bit accumulator register does the work. At the start its lower half holds the multiplier and its upper half is cleared. A 32-bit multiplicand register stays unchanged for the whole operation. Each step can update the upper half of the accumulator. The whole register then shifts right by one bit, so the multiplier bits leave through bit 0 while the product fills the register from the top.

There are two modes. In unsigned mode the bit that is about to leave decides whether the multiplicand is added to the upper half. The carry out of that addition becomes the new bit 63. In signed mode the step uses radix-2 Booth recoding. The leaving bit and the bit that left on the previous step together choose add, subtract or no change. The shift is arithmetic. The upper half is handled in 33 bits, so the most negative operand gives a correct result.

A client pulses `start` while the block is idle. It reads `product` when `done` pulses.

Top module: `seq_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` seen while idle is accepted at that clock edge. `busy` is 1 from the next cycle. `done` rises exactly 32 clock edges after the accepting edge, once the 32 iterations are complete.
- R3: When `signed_mode` is 0 at acceptance, `product` equals the unsigned product of `multiplicand` and `multiplier` across all 64 bits.
- R4: When `signed_mode` is 1 at acceptance, `product` equals the two's-complement product of the operands across all 64 bits.
- R5: Signed results are correct when either operand, or both, equals -2^31.
- R6: `done` is high for exactly one cycle. In that cycle `busy` is 0, and `busy` was 1 in the cycle before.
- R7: A `start` raised while `busy` is 1 is ignored. New operand values presented with it do not change the result in progress.
- R8: After `done`, `product` keeps its value until the next accepted `start`.
- R9: The mode is captured at acceptance. Changing `signed_mode` during the operation does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication (accepted only when idle) |
| signed_mode | input | 1 | 1 = two's-complement Booth mode, 0 = unsigned |
| multiplicand | input | 32 | First operand, held in a fixed register |
| multiplier | input | 32 | Second operand, loaded into the low half of the accumulator |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when `product` is final |
| product | output | 64 | Accumulator contents; the result once `done` pulses |

## Verification
The in-module assertions watch the protocol on every cycle:
- the run length of 32 busy cycles before `done`;
- that `done` is a single-cycle pulse following busy;
- that the multiplicand and the mode stay frozen during a run;
- that the product holds while idle.

Only the bench's scenarios can show that the arithmetic is right. These cover:
- unsigned and signed products, including carries out of the upper half and the -2^31 operand cases;
- that operands or a mode change offered mid-run leave the result untouched.

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W);

  logic [W-1:0]   mcand;
  logic [2*W-1:0] acc;
  logic           prev, sgn_q;
  logic [CW-1:0]  step;

  wire accept = start && !busy;

  wire [W:0] hi_ext = sgn_q ? {acc[2*W-1], acc[2*W-1:W]} : {1'b0, acc[2*W-1:W]};
  wire [W:0] mc_ext = sgn_q ? {mcand[W-1], mcand} : {1'b0, mcand};

  wire do_sub = sgn_q && acc[0] && !prev;
  wire do_add = sgn_q ? (!acc[0] && prev) : acc[0];

  wire [W:0] upd = do_sub ? hi_ext - mc_ext :
                   do_add ? hi_ext + mc_ext : hi_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0;
      acc   <= '0;
      prev  <= 1'b0;
      sgn_q <= 1'b0;
      step  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mcand <= multiplicand;
        acc   <= {{W{1'b0}}, multiplier};
        prev  <= 1'b0;
        sgn_q <= signed_mode;
        step  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        acc  <= {upd, acc[W-1:1]};
        prev <= acc[0];
        step <= step + 1'b1;
        if (step == CW'(W-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = acc;

  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (accept)  run_len <= '0;
    else if (busy)    run_len <= run_len + 1'b1;
  end

  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == (CW+1)'(W));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_operand_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sgn_q));
endmodule

// File: tb/seq_mult_bench.sv
module seq_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] multiplicand = '0;
  logic [31:0] multiplier = '0;
  logic        busy, done;
  logic [63:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  seq_mult u_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint sa, sb;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  // disturb: offer other operands with start and flip the mode mid-run (R7, R9)
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit s,
                        input bit disturb, input string tag);
    logic [63:0] exp;
    int cyc;
    exp = model(a, b, s);
    @(negedge clk);
    multiplicand = a; multiplier = b; signed_mode = s; start = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    if (disturb) begin
      repeat (3) @(negedge clk);
      cyc += 3;
      multiplicand = ~a; multiplier = b ^ 32'h5A5A_1234; signed_mode = ~s; start = 1'b1;
      @(negedge clk);
      cyc++;
      start = 1'b0;
    end
    while (done !== 1'b1) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 33, "R2 done latency", 64'(cyc), 64'd33);
    @(negedge clk);
    check(done === 1'b0, "R6 done single pulse", 64'(done), 64'd0);
    repeat (2) @(negedge clk);
    check(product === exp, "R8 product holds after done", product, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && done === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(product === e, t, product, e);
        check(busy === 1'b0, "R6 busy low with done", 64'(busy), 64'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {62'b0, busy, done}, 64'd0);
    check(product === 64'd0, "R1 reset product", product, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(32'd7, 32'd9, 1'b0, 1'b0, "R3 small unsigned");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3 max unsigned carry");
    run_op(32'h8000_0001, 32'h0000_0003, 1'b0, 1'b0, "R3 top bit unsigned");
    run_op(32'd0, 32'h1234_5678, 1'b0, 1'b0, "R3 zero operand");
    run_op(32'hDEAD_BEEF, 32'h1357_9BDF, 1'b0, 1'b0, "R3 mixed unsigned");
    run_op(32'hFFFF_FFFD, 32'd5, 1'b1, 1'b0, "R4 neg times pos");
    run_op(32'hFFFF_FFF9, 32'hFFFF_FFF5, 1'b1, 1'b0, "R4 neg times neg");
    run_op(32'h1234_5678, 32'hAAAA_5555, 1'b1, 1'b0, "R4 alternating bits");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R5 min times min");
    run_op(32'h8000_0000, 32'd1, 1'b1, 1'b0, "R5 min times one");
    run_op(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, "R5 max times min");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5 min times minus one");
    run_op(32'h0001_0003, 32'h0000_FFFF, 1'b0, 1'b1, "R7 R9 start ignored unsigned");
    run_op(32'hFFFF_8000, 32'h0000_7001, 1'b1, 1'b1, "R7 R9 start ignored signed");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results seen", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule